// File: doc/BRIEF.md
# Key-Protected Oscillator Control Register Block

This block is a small register slave on an APB-style peripheral bus that governs the clock sources of a chip. It holds three registers: a write-only unlock word, a guarded oscillator control register, and a clock-source selection register. The oscillator control register carries the high-frequency oscillator enable. It also reports two read-only "oscillator stable" flags that come from the analog side.

The guard is a one-shot unlock. A write to the control register is accepted only if the single bus write just before it put the correct 32-bit unlock word into the unlock register. Any other bus write in between re-locks the block. This includes a write to the clock-select register or to an unmapped address. Every control write, accepted or dropped, also uses up the unlock.

The clock-source selection register is not guarded. It drives the select lines of a downstream clock multiplexer, and it keeps its old value when software writes one of the two reserved codes.

Top module: `osc_keyctl_regs`

## Requirements
- R1: After reset the control register (offset 0x110) reads 0x302 while both stable inputs are high, `hf_osc_en_o` is 1, `clk_src_sel_o` is 00, the select register (offset 0x300) reads 0, and the block is locked.
- R2: Writing 0x0000CB14 to the unlock register (offset 0x10C) and then, as the very next bus write, writing the control register copies write-data bit 1 into the enable. The new value appears on `hf_osc_en_o` and in read-back bit 1.
- R3: A control register write that is not directly preceded by a correct unlock write leaves the enable unchanged.
- R4: A bus write to any other address (the select register or an unmapped offset) between the unlock write and the control write re-locks the block, so that control write is dropped.
- R5: An unlock write of any other 32-bit value leaves the block locked. This includes 0xCB14 with nonzero bits [31:16]. The unlock register always reads 0.
- R6: Read transfers between the unlock write and the control write do not change the lock state.
- R7: After an accepted control write the block is locked again, so a second control write with no new unlock is dropped.
- R8: Control read-back bit 9 (high-frequency stable) equals the enable AND the high-frequency stable input. It reads 0 whenever the enable is 0.
- R9: Control read-back bit 8 (low-frequency stable) follows the low-frequency stable input.
- R10: Control bit 0 and bits [7:2] and [31:10] always read 0, even after an accepted write of all ones.
- R11: A write of 00 or 11 to select bits [1:0] takes effect at once on `clk_src_sel_o` and in read-back. 00 is the internal high-frequency oscillator and 11 is the external clock. The select register needs no unlock.
- R12: A write of the reserved select codes 01 or 10 is ignored and the previous selection is kept.
- R13: Select bits [31:2] and every unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 12 | Byte offset within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected |
| hf_stable_i | input | 1 | High-frequency oscillator reports stable |
| lf_stable_i | input | 1 | Low-frequency oscillator reports stable |
| hf_osc_en_o | output | 1 | High-frequency oscillator enable |
| clk_src_sel_o | output | 2 | Clock multiplexer select code |

## Verification
The assertions assume a well-formed two-phase bus. A transfer is a setup cycle with `psel` high and `penable` low, followed by a single access cycle. Address and data stay stable through both cycles. They also assume that the stable inputs are synchronous to `pclk`. The bench drives every transfer through one task that produces exactly this shape with zero wait states. It changes the stable inputs only while the bus is idle, so every read samples settled status.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_UNLOCK = 12'h10C;
  localparam logic [ADDR_W-1:0] OFS_OSCCTL = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_CLKSEL = 12'h300;
  localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h0000_CB14;

  typedef enum logic [1:0] {
    SRC_HFOSC = 2'b00,
    SRC_RSV1  = 2'b01,
    SRC_RSV2  = 2'b10,
    SRC_EXT   = 2'b11
  } clk_src_e;

  function automatic logic sel_code_legal(input logic [1:0] code);
    return (code == SRC_HFOSC) || (code == SRC_EXT);
  endfunction

  function automatic logic [DATA_W-1:0] pack_oscctl(input logic en,
                                                    input logic hf_ok,
                                                    input logic lf_ok);
    logic [DATA_W-1:0] w;
    w    = '0;
    w[9] = hf_ok;
    w[8] = lf_ok;
    w[1] = en;
    return w;
  endfunction
endpackage

// File: rtl/osc_addr_dec.sv
module osc_addr_dec #(
  parameter int AW = 12,
  parameter logic [AW-1:0] A_UNLOCK = '0,
  parameter logic [AW-1:0] A_OSCCTL = '0,
  parameter logic [AW-1:0] A_CLKSEL = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit_unlock,
  output logic          hit_oscctl,
  output logic          hit_clksel
);
  assign hit_unlock = (addr == A_UNLOCK);
  assign hit_oscctl = (addr == A_OSCCTL);
  assign hit_clksel = (addr == A_CLKSEL);
endmodule

// File: rtl/osc_lock_fsm.sv
module osc_lock_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_evt,
  input  logic rd_evt,
  input  logic key_ok,
  output logic unlocked
);
  logic unlocked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked_q <= 1'b0;
    else if (wr_evt) unlocked_q <= key_ok;
  end

  assign unlocked = unlocked_q;

  assert_read_keeps_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !wr_evt) |=> $stable(unlocked_q));

  assert_bad_write_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !key_ok) |=> !unlocked_q);
endmodule

// File: rtl/osc_readmux.sv
module osc_readmux
  import osc_pkg::*;
(
  input  logic              sel,
  input  logic              hit_oscctl,
  input  logic              hit_clksel,
  input  logic              en,
  input  logic              hf_ok,
  input  logic              lf_ok,
  input  logic [1:0]        src,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (sel) begin
      if (hit_oscctl)      rdata = pack_oscctl(en, hf_ok, lf_ok);
      else if (hit_clksel) rdata = {{(DATA_W-2){1'b0}}, src};
    end
  end
endmodule

// File: rtl/osc_keyctl_regs.sv
module osc_keyctl_regs
  import osc_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_WORD = UNLOCK_WORD
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              hf_stable_i,
  input  logic              lf_stable_i,
  output logic              hf_osc_en_o,
  output logic [1:0]        clk_src_sel_o
);
  logic hit_unlock, hit_oscctl, hit_clksel;
  logic wr_evt, rd_evt, key_ok, unlocked;
  logic ctl_commit, sel_commit;
  logic hf_en_q;
  logic [1:0] src_q;
  logic hf_ok;

  osc_addr_dec #(
    .AW(ADDR_W), .A_UNLOCK(OFS_UNLOCK), .A_OSCCTL(OFS_OSCCTL), .A_CLKSEL(OFS_CLKSEL)
  ) u_dec (
    .addr(paddr), .hit_unlock(hit_unlock), .hit_oscctl(hit_oscctl), .hit_clksel(hit_clksel)
  );

  assign wr_evt = psel && penable && pwrite;
  assign rd_evt = psel && penable && !pwrite;
  assign key_ok = hit_unlock && (pwdata == KEY_WORD);

  osc_lock_fsm u_lock (
    .clk(pclk), .rst_n(presetn), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .key_ok(key_ok), .unlocked(unlocked)
  );

  assign ctl_commit = wr_evt && hit_oscctl && unlocked;
  assign sel_commit = wr_evt && hit_clksel && sel_code_legal(pwdata[1:0]);

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      hf_en_q <= 1'b1;
      src_q   <= SRC_HFOSC;
    end else begin
      if (ctl_commit) hf_en_q <= pwdata[1];
      if (sel_commit) src_q   <= pwdata[1:0];
    end
  end

  assign hf_ok = hf_en_q && hf_stable_i;

  osc_readmux u_rd (
    .sel(psel), .hit_oscctl(hit_oscctl), .hit_clksel(hit_clksel),
    .en(hf_en_q), .hf_ok(hf_ok), .lf_ok(lf_stable_i), .src(src_q), .rdata(prdata)
  );

  assign hf_osc_en_o   = hf_en_q;
  assign clk_src_sel_o = src_q;

  assert_en_change_needs_unlock_R2: assert property (@(posedge pclk) disable iff (!presetn)
    !$stable(hf_en_q) |-> $past(unlocked));

  assert_locked_ctl_dropped_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_evt && hit_oscctl && !unlocked) |=> $stable(hf_osc_en_o));

  assert_commit_relocks_R7: assert property (@(posedge pclk) disable iff (!presetn)
    ctl_commit |=> !unlocked);

  assert_hfok_gated_R8: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && hit_oscctl && !hf_osc_en_o) |-> !prdata[9]);

  assert_reserved_zero_R10: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && hit_oscctl) |-> (prdata[31:10] == '0 && prdata[7:2] == '0 && !prdata[0]));

  assert_sel_never_reserved_R12: assert property (@(posedge pclk) disable iff (!presetn)
    (clk_src_sel_o != SRC_RSV1) && (clk_src_sel_o != SRC_RSV2));
endmodule

// File: tb/osc_keyctl_regs_test.sv
`timescale 1ns/1ps
module osc_keyctl_regs_test;
  localparam logic [11:0] A_KEY = 12'h10C;
  localparam logic [11:0] A_CTL = 12'h110;
  localparam logic [11:0] A_SEL = 12'h300;

  typedef struct {
    logic [31:0] exp;
    logic [11:0] addr;
    int          rid;
  } rd_item_t;

  logic        pclk = 0, presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        hf_st = 1, lf_st = 1;
  logic        hf_en_o;
  logic [1:0]  sel_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  rd_item_t exp_q[$];

  logic       m_en = 1, m_unl = 0;
  logic [1:0] m_sel = 2'b00;

  always #2.5 pclk = ~pclk;

  osc_keyctl_regs uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .hf_stable_i(hf_st), .lf_stable_i(lf_st),
    .hf_osc_en_o(hf_en_o), .clk_src_sel_o(sel_o)
  );

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic [31:0] w;
    w = '0;
    if (a == A_CTL) begin
      w[9] = m_en & hf_st;
      w[8] = lf_st;
      w[1] = m_en;
    end else if (a == A_SEL) begin
      w[1:0] = m_sel;
    end
    return w;
  endfunction

  task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(posedge pclk); #1;
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge pclk); #1;
    penable = 1;
    @(posedge pclk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    if (a == A_CTL && m_unl) m_en = d[1];
    if (a == A_SEL && (d[1:0] == 2'b00 || d[1:0] == 2'b11)) m_sel = d[1:0];
    m_unl = (a == A_KEY) && (d == 32'h0000_CB14);
    bus(1'b1, a, d);
  endtask

  task automatic rd(input logic [11:0] a, input int rid);
    rd_item_t it;
    it.exp = model_read(a); it.addr = a; it.rid = rid;
    exp_q.push_back(it);
    bus(1'b0, a, '0);
  endtask

  task automatic chk_port(input int rid, input logic [31:0] act, input logic [31:0] exp);
    @(negedge pclk);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d port: actual %0h expected %0h", rid, act, exp);
    end
  endtask

  always @(negedge pclk) begin
    if (psel && penable && !pwrite && exp_q.size() > 0) begin
      rd_item_t it;
      it = exp_q.pop_front();
      n_cmp++;
      if (prdata !== it.exp) begin
        n_bad++;
        $display("FAIL R%0d read @%0h: actual %0h expected %0h", it.rid, it.addr, prdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge pclk); #1;
    presetn = 1;
    // R1 reset state
    rd(A_CTL, 1);
    chk_port(1, {31'b0, hf_en_o}, 32'd1);
    chk_port(1, {30'b0, sel_o}, 32'd0);
    rd(A_SEL, 1);
    // R3 locked write dropped
    wr(A_CTL, 32'h0);
    rd(A_CTL, 3);
    chk_port(3, {31'b0, hf_en_o}, 32'd1);
    // R2 unlock then write; R8 hf ok forced low
    wr(A_KEY, 32'h0000_CB14); wr(A_CTL, 32'h0);
    chk_port(2, {31'b0, hf_en_o}, 32'd0);
    rd(A_CTL, 8);
    // R7 relock after commit
    wr(A_KEY, 32'h0000_CB14); wr(A_CTL, 32'h2);
    wr(A_CTL, 32'h0);
    chk_port(7, {31'b0, hf_en_o}, 32'd1);
    rd(A_CTL, 7);
    // R4 intervening select write; R11 select takes 11
    wr(A_KEY, 32'h0000_CB14); wr(A_SEL, 32'h3); wr(A_CTL, 32'h0);
    chk_port(4, {31'b0, hf_en_o}, 32'd1);
    chk_port(11, {30'b0, sel_o}, 32'd3);
    // R4 intervening unmapped write
    wr(A_KEY, 32'h0000_CB14); wr(12'h200, 32'h0); wr(A_CTL, 32'h0);
    chk_port(4, {31'b0, hf_en_o}, 32'd1);
    // R5 wrong keys
    wr(A_KEY, 32'h0000_CB15); wr(A_CTL, 32'h0);
    chk_port(5, {31'b0, hf_en_o}, 32'd1);
    wr(A_KEY, 32'h0001_CB14); wr(A_CTL, 32'h0);
    chk_port(5, {31'b0, hf_en_o}, 32'd1);
    rd(A_KEY, 5);
    // R6 reads keep unlock
    wr(A_KEY, 32'h0000_CB14); rd(A_CTL, 6); rd(A_SEL, 6); wr(A_CTL, 32'h0);
    chk_port(6, {31'b0, hf_en_o}, 32'd0);
    // R10 all-ones accepted write, reserved read 0
    wr(A_KEY, 32'h0000_CB14); wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, 10);
    // R9 lf status, R8 hf status
    @(posedge pclk); #1; lf_st = 0;
    rd(A_CTL, 9);
    @(posedge pclk); #1; hf_st = 0;
    rd(A_CTL, 8);
    @(posedge pclk); #1; hf_st = 1; lf_st = 1;
    rd(A_CTL, 9);
    // R12 reserved select codes ignored
    wr(A_SEL, 32'h1);
    chk_port(12, {30'b0, sel_o}, 32'd3);
    wr(A_SEL, 32'h2);
    rd(A_SEL, 12);
    // R11 select back to 00
    wr(A_SEL, 32'hFFFF_FFFC);
    chk_port(11, {30'b0, sel_o}, 32'd0);
    // R13 reserved select bits and unmapped read
    wr(A_SEL, 32'hFFFF_FFFF);
    rd(A_SEL, 13);
    rd(12'h004, 13);
    repeat (2) @(posedge pclk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule